// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

A small 32-bit processor that finishes every instruction in one clock. It supports these instruction groups:

- register-to-register arithmetic and logic,
- word load and word store,
- branch when two registers are equal,
- unconditional jump.

The program counter, the instruction array, the data array, a 32-entry register file, the main decoder, the ALU decoder and the ALU are all inside the block. Instruction fetch and data access use separate arrays, so both can happen in the same cycle.

Before the core runs, a load port fills the instruction array and the data array. Two inspection ports read any register and any data word combinationally, so the final machine state can be examined from outside. The current program counter is visible at all times.

Top module: `sc_core`

## Requirements
- R1: While rst_ni is low, the PC is 0 and every register reads as 0. The PC restarts from 0 when reset is released.
- R2: An instruction with opcode 000000 takes rs from bits 25-21, rt from 20-16 and rd from 15-11, and writes the result to rd. The function code in bits 5-0 selects the operation: 100000 add, 100010 subtract, 100100 and, 100101 or, 100110 xor, 100111 nor, 101010 set-if-less-than (signed).
- R3: Opcode 100011 (load) writes data word (rs + sign-extended bits 15-0) / 4 into register rt. Negative offsets are allowed.
- R4: Opcode 101011 (store) writes rt into data word (rs + sign-extended offset) / 4 and writes no register.
- R5: Opcode 000100 (branch-if-equal) sets the next PC to PC+4+(sign-extended offset << 2) when rs equals rt, and to PC+4 otherwise. It writes nothing.
- R6: Opcode 000010 (jump) sets the next PC to {PC+4 bits 31-28, bits 25-0, 2'b00} and writes nothing.
- R7: Register 0 always reads 0, and a write that targets it is dropped.
- R8: Any other opcode writes no register and no memory, and the PC advances by 4.
- R9: Every instruction that is not a taken branch or a jump advances the PC by 4. The PC stays word aligned.
- R10: When ld_we_i is high, ld_data_i is written on the clock edge into the instruction array (ld_sel_i=0) or the data array (ld_sel_i=1) at word ld_addr_i. The inspection ports return register and data-word contents combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_we_i | input | 1 | Load strobe for the arrays |
| ld_sel_i | input | 1 | Load target: 0 instruction array, 1 data array |
| ld_addr_i | input | AW | Word index to load |
| ld_data_i | input | 32 | Word to load |
| dbg_reg_addr_i | input | 5 | Register to inspect |
| dbg_reg_data_o | output | 32 | Contents of the inspected register |
| dbg_mem_addr_i | input | AW | Data word to inspect |
| dbg_mem_data_o | output | 32 | Contents of the inspected data word |
| pc_o | output | 32 | Current program counter |

## Verification
The assertions check properties that must hold on every cycle:

- register 0 always reads zero,
- the PC stays word aligned,
- a non-control instruction advances the PC by 4,
- a jump lands on the concatenated target,
- a store and an unknown opcode never write a register, and an unknown opcode never writes memory.

The bench's program covers what a per-cycle property cannot show:

- that each function code gives the right arithmetic result,
- that signed comparison and negative load offsets work,
- that a not-taken and a taken branch each go to the right place,
- that skipped instructions leave registers and memory untouched.

A scoreboard compares the PC trace cycle by cycle, and the final registers and data words are checked through the inspection ports.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_LW    = 6'b100011;
  localparam logic [5:0] OP_SW    = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_J     = 6'b000010;

  typedef enum logic [1:0] {
    AOP_ADD  = 2'b00,
    AOP_SUB  = 2'b01,
    AOP_FUNC = 2'b10
  } alu_op_e;

  typedef enum logic [3:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_XOR = 4'b0010,
    ALU_NOR = 4'b0011,
    ALU_ADD = 4'b0110,
    ALU_SUB = 4'b1110,
    ALU_SLT = 4'b1111
  } alu_ctl_e;

  typedef struct packed {
    logic    reg_dst;
    logic    alu_src;
    logic    mem_to_reg;
    logic    reg_write;
    logic    mem_read;
    logic    mem_write;
    logic    branch;
    logic    jump;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
  import sc_pkg::*;
(
  input  logic [5:0] op_i,
  output ctrl_t      ctrl_o
);
  always_comb begin
    ctrl_o = '{default: '0, alu_op: AOP_ADD};
    unique case (op_i)
      OP_RTYPE: begin
        ctrl_o.reg_dst   = 1'b1;
        ctrl_o.reg_write = 1'b1;
        ctrl_o.alu_op    = AOP_FUNC;
      end
      OP_LW: begin
        ctrl_o.alu_src    = 1'b1;
        ctrl_o.mem_to_reg = 1'b1;
        ctrl_o.reg_write  = 1'b1;
        ctrl_o.mem_read   = 1'b1;
      end
      OP_SW: begin
        ctrl_o.alu_src   = 1'b1;
        ctrl_o.mem_write = 1'b1;
      end
      OP_BEQ: begin
        ctrl_o.branch = 1'b1;
        ctrl_o.alu_op = AOP_SUB;
      end
      OP_J: ctrl_o.jump = 1'b1;
      default: ;  // unknown opcode: no-op
    endcase
  end
endmodule

// File: rtl/sc_alu_dec.sv
module sc_alu_dec
  import sc_pkg::*;
(
  input  alu_op_e    alu_op_i,
  input  logic [5:0] funct_i,
  output alu_ctl_e   ctl_o
);
  always_comb begin
    ctl_o = ALU_ADD;
    unique case (alu_op_i)
      AOP_SUB:  ctl_o = ALU_SUB;
      AOP_FUNC: begin
        unique case (funct_i)
          6'b100000: ctl_o = ALU_ADD;
          6'b100010: ctl_o = ALU_SUB;
          6'b100100: ctl_o = ALU_AND;
          6'b100101: ctl_o = ALU_OR;
          6'b100110: ctl_o = ALU_XOR;
          6'b100111: ctl_o = ALU_NOR;
          6'b101010: ctl_o = ALU_SLT;
          default:   ctl_o = ALU_ADD;
        endcase
      end
      default: ctl_o = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_ctl_e       ctl_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [W-1:0]   res_o,
  output logic           zero_o
);
  always_comb begin
    unique case (ctl_i)
      ALU_AND: res_o = a_i & b_i;
      ALU_OR:  res_o = a_i | b_i;
      ALU_XOR: res_o = a_i ^ b_i;
      ALU_NOR: res_o = ~(a_i | b_i);
      ALU_ADD: res_o = a_i + b_i;
      ALU_SUB: res_o = a_i - b_i;
      ALU_SLT: res_o = {{(W-1){1'b0}}, $signed(a_i) < $signed(b_i)};
      default: res_o = '0;
    endcase
  end
  assign zero_o = (res_o == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32,
  localparam int RAW = $clog2(NREG)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [RAW-1:0] ra_a_i,
  input  logic [RAW-1:0] ra_b_i,
  input  logic [RAW-1:0] ra_c_i,
  output logic [W-1:0]   rd_a_o,
  output logic [W-1:0]   rd_b_o,
  output logic [W-1:0]   rd_c_o,
  input  logic           we_i,
  input  logic [RAW-1:0] wa_i,
  input  logic [W-1:0]   wd_i
);
  logic [W-1:0] q [NREG];

  // entry 0 is only ever reset, never written
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) q[i] <= '0;
    end else begin
      for (int i = 1; i < NREG; i++)
        if (we_i && wa_i == RAW'(i)) q[i] <= wd_i;
    end
  end

  assign rd_a_o = q[ra_a_i];
  assign rd_b_o = q[ra_b_i];
  assign rd_c_o = q[ra_c_i];
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int MEM_WORDS = 64,
  localparam int AW = $clog2(MEM_WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_we_i,
  input  logic          ld_sel_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic [31:0]   ld_data_i,
  input  logic [4:0]    dbg_reg_addr_i,
  output logic [31:0]   dbg_reg_data_o,
  input  logic [AW-1:0] dbg_mem_addr_i,
  output logic [31:0]   dbg_mem_data_o,
  output logic [31:0]   pc_o
);
  logic [31:0] imem [MEM_WORDS];
  logic [31:0] dmem [MEM_WORDS];

  logic [31:0] pc_q, pc_nx, pc4, instr;
  logic [5:0]  op, funct;
  logic [4:0]  rs, rt, rd, wr_addr;
  logic [31:0] rs_data, rt_data, imm_ext, alu_b, alu_res, dm_rdata, wb_data;
  logic [31:0] br_tgt, jmp_tgt;
  logic        alu_zero, rf_we, dm_we;
  ctrl_t       ctrl;
  alu_ctl_e    alu_ctl;

  // fetch and field split
  assign pc4   = pc_q + 32'd4;
  assign instr = imem[pc_q[AW+1:2]];
  assign op    = instr[31:26];
  assign rs    = instr[25:21];
  assign rt    = instr[20:16];
  assign rd    = instr[15:11];
  assign funct = instr[5:0];
  assign imm_ext = {{16{instr[15]}}, instr[15:0]};

  sc_ctrl u_ctrl (.op_i(op), .ctrl_o(ctrl));

  sc_alu_dec u_alu_dec (.alu_op_i(ctrl.alu_op), .funct_i(funct), .ctl_o(alu_ctl));

  sc_regfile #(.W(32), .NREG(32)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ra_a_i (rs),
    .ra_b_i (rt),
    .ra_c_i (dbg_reg_addr_i),
    .rd_a_o (rs_data),
    .rd_b_o (rt_data),
    .rd_c_o (dbg_reg_data_o),
    .we_i   (rf_we),
    .wa_i   (wr_addr),
    .wd_i   (wb_data)
  );

  assign alu_b = ctrl.alu_src ? imm_ext : rt_data;

  sc_alu #(.W(32)) u_alu (
    .ctl_i  (alu_ctl),
    .a_i    (rs_data),
    .b_i    (alu_b),
    .res_o  (alu_res),
    .zero_o (alu_zero)
  );

  // data side
  assign dm_rdata = dmem[alu_res[AW+1:2]];
  assign dm_we    = ctrl.mem_write;
  assign rf_we    = ctrl.reg_write;
  assign wr_addr  = ctrl.reg_dst ? rd : rt;
  assign wb_data  = ctrl.mem_to_reg ? (ctrl.mem_read ? dm_rdata : '0) : alu_res;

  // load port has priority over a program store
  always_ff @(posedge clk_i) begin
    if (ld_we_i && !ld_sel_i) imem[ld_addr_i] <= ld_data_i;
    if (ld_we_i && ld_sel_i) dmem[ld_addr_i] <= ld_data_i;
    else if (dm_we) dmem[alu_res[AW+1:2]] <= rt_data;
  end

  assign dbg_mem_data_o = dmem[dbg_mem_addr_i];

  // next PC
  assign br_tgt  = pc4 + {imm_ext[29:0], 2'b00};
  assign jmp_tgt = {pc4[31:28], instr[25:0], 2'b00};

  always_comb begin
    if (ctrl.jump)                     pc_nx = jmp_tgt;
    else if (ctrl.branch && alu_zero)  pc_nx = br_tgt;
    else                               pc_nx = pc4;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_nx;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
  import sc_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] pc_i,
  input logic [31:0] instr_i,
  input logic        rf_we_i,
  input logic        dm_we_i,
  input logic [4:0]  dbg_addr_i,
  input logic [31:0] dbg_data_i
);
  logic [5:0]  op;
  logic [31:0] pc_plus4, jt;
  logic        known;

  assign op       = instr_i[31:26];
  assign pc_plus4 = pc_i + 32'd4;
  assign jt       = {pc_plus4[31:28], instr_i[25:0], 2'b00};
  assign known    = op inside {OP_RTYPE, OP_LW, OP_SW, OP_BEQ, OP_J};

  assert_reg0_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_addr_i == 5'd0) |-> (dbg_data_i == 32'd0));

  assert_pc_aligned_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_i[1:0] == 2'b00);

  assert_seq_pc_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op != OP_BEQ && op != OP_J) |=> (pc_i == $past(pc_plus4)));

  assert_jump_tgt_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_J) |=> (pc_i == $past(jt)));

  assert_store_norf_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_SW) |-> (!rf_we_i && dm_we_i));

  assert_unknown_nop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !known |-> (!rf_we_i && !dm_we_i));
endmodule

bind sc_core sc_core_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pc_i       (pc_o),
  .instr_i    (instr),
  .rf_we_i    (rf_we),
  .dm_we_i    (dm_we),
  .dbg_addr_i (dbg_reg_addr_i),
  .dbg_data_i (dbg_reg_data_o)
);

// File: tb/tb_sc_core.sv
`timescale 1ns/1ps
module tb_sc_core;
  localparam int MW = 64;
  localparam int AW = $clog2(MW);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          ld_we_i = 1'b0, ld_sel_i = 1'b0;
  logic [AW-1:0] ld_addr_i = '0;
  logic [31:0]   ld_data_i = '0;
  logic [4:0]    dbg_reg_addr_i = '0;
  logic [31:0]   dbg_reg_data_o;
  logic [AW-1:0] dbg_mem_addr_i = '0;
  logic [31:0]   dbg_mem_data_o;
  logic [31:0]   pc_o;

  always #4 clk_i = ~clk_i;  // 125 MHz

  sc_core #(.MEM_WORDS(MW)) dut (.*);

  typedef struct { logic [31:0] pc; string tag; } exp_t;
  exp_t exp_q[$];
  int total = 0, bad = 0;
  bit mon_done = 0;

  function automatic logic [31:0] r_ins(int rs, int rt, int rd, logic [5:0] fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] i_ins(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ld(bit sel, int addr, logic [31:0] data);
    ld_we_i = 1'b1; ld_sel_i = sel; ld_addr_i = AW'(addr); ld_data_i = data;
    @(posedge clk_i); #1;
    ld_we_i = 1'b0;
  endtask

  task automatic push_pc(logic [31:0] pc, string tag);
    exp_t e;
    e.pc = pc; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic chk_reg(int r, logic [31:0] exp, string tag);
    dbg_reg_addr_i = 5'(r); #1;
    check($sformatf("%s reg%0d", tag, r), dbg_reg_data_o, exp);
  endtask

  task automatic chk_mem(int a, logic [31:0] exp, string tag);
    dbg_mem_addr_i = AW'(a); #1;
    check($sformatf("%s mem%0d", tag, a), dbg_mem_data_o, exp);
  endtask

  // monitor: compares PC trace against the scoreboard
  initial begin
    exp_t e;
    @(posedge rst_ni); #1;
    while (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      check({e.tag, " pc"}, pc_o, e.pc);
      @(negedge clk_i); #1;
    end
    mon_done = 1;
  end

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // fill arrays: instruction array with an undefined opcode, data with a pattern
    for (int i = 0; i < MW; i++) ld(1'b0, i, 32'hFC00_0000);
    for (int i = 0; i < MW; i++) ld(1'b1, i, 32'h100 + i);
    ld(1'b1, 0, 32'd5);
    ld(1'b1, 1, 32'd7);
    ld(1'b1, 2, 32'hFFFF_FFFD);
    ld(1'b1, 3, 32'd7);

    ld(1'b0,  0, i_ins(6'h23, 0, 1, 16'd0));       // lw r1
    ld(1'b0,  1, i_ins(6'h23, 0, 2, 16'd4));       // lw r2
    ld(1'b0,  2, i_ins(6'h23, 0, 3, 16'd8));       // lw r3
    ld(1'b0,  3, r_ins(1, 2, 4, 6'b100000));       // add
    ld(1'b0,  4, r_ins(1, 2, 5, 6'b100010));       // sub
    ld(1'b0,  5, r_ins(1, 2, 6, 6'b100100));       // and
    ld(1'b0,  6, r_ins(1, 2, 7, 6'b100101));       // or
    ld(1'b0,  7, r_ins(1, 2, 8, 6'b100110));       // xor
    ld(1'b0,  8, r_ins(1, 2, 9, 6'b100111));       // nor
    ld(1'b0,  9, r_ins(3, 1, 10, 6'b101010));      // slt -3<5
    ld(1'b0, 10, r_ins(1, 3, 11, 6'b101010));      // slt 5<-3
    ld(1'b0, 11, r_ins(1, 2, 0, 6'b100000));       // add into r0
    ld(1'b0, 12, i_ins(6'h2B, 0, 4, 16'd16));      // sw r4 -> word4
    ld(1'b0, 13, i_ins(6'h23, 0, 12, 16'd16));     // lw r12
    ld(1'b0, 14, i_ins(6'h04, 1, 2, 16'd5));       // beq not taken
    ld(1'b0, 15, i_ins(6'h04, 2, 2, 16'd2));       // beq taken -> 0x48
    ld(1'b0, 16, i_ins(6'h2B, 0, 1, 16'd20));      // skipped
    ld(1'b0, 17, r_ins(1, 1, 13, 6'b100000));      // skipped
    ld(1'b0, 18, {6'b000010, 26'd21});             // j 0x54
    ld(1'b0, 19, i_ins(6'h2B, 0, 2, 16'd20));      // skipped
    ld(1'b0, 20, r_ins(1, 1, 14, 6'b100000));      // skipped
    ld(1'b0, 21, i_ins(6'h23, 4, 15, 16'hFFF8));   // lw r15,-8(r4)
    ld(1'b0, 22, 32'hFC00_0000);                   // undefined opcode
    ld(1'b0, 23, i_ins(6'h2B, 0, 5, 16'd24));      // sw r5 -> word6
    ld(1'b0, 24, i_ins(6'h04, 0, 0, 16'hFFFF));    // self loop

    // scoreboard of expected PC trace
    push_pc(32'h0, "R1");
    for (int i = 1; i < 16; i++) push_pc(32'(4 * i), "R9");
    push_pc(32'h48, "R5");
    push_pc(32'h54, "R6");
    push_pc(32'h58, "R9");
    push_pc(32'h5C, "R8");
    push_pc(32'h60, "R9");
    push_pc(32'h60, "R5");
    push_pc(32'h60, "R5");

    // reset state
    @(negedge clk_i); #1;
    check("R1 pc in reset", pc_o, 32'h0);
    chk_reg(4, 32'h0, "R1");

    @(negedge clk_i);
    rst_ni = 1'b1;
    wait (mon_done);
    @(negedge clk_i);

    chk_reg(0,  32'h0,        "R7");
    chk_reg(1,  32'd5,        "R3");
    chk_reg(2,  32'd7,        "R3");
    chk_reg(3,  32'hFFFF_FFFD,"R3");
    chk_reg(4,  32'd12,       "R2");
    chk_reg(5,  32'hFFFF_FFFE,"R2");
    chk_reg(6,  32'd5,        "R2");
    chk_reg(7,  32'd7,        "R2");
    chk_reg(8,  32'd2,        "R2");
    chk_reg(9,  32'hFFFF_FFF8,"R2");
    chk_reg(10, 32'd1,        "R2");
    chk_reg(11, 32'd0,        "R2");
    chk_reg(12, 32'd12,       "R4");
    chk_reg(13, 32'd0,        "R5");
    chk_reg(14, 32'd0,        "R6");
    chk_reg(15, 32'd7,        "R3");
    chk_mem(4,  32'd12,       "R4");
    chk_mem(5,  32'h105,      "R5");
    chk_mem(6,  32'hFFFF_FFFE,"R4");
    chk_mem(7,  32'h107,      "R8");
    chk_mem(0,  32'd5,        "R10");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule